// File: doc/BRIEF.md
# Banked Memory Paging Controller

This block sits between a CPU with a 16-bit address bus and a physical store of four 16 KB ROM pages and eight 16 KB RAM pages. The CPU space is cut into four 16 KB slots, chosen by the top two address bits. For each access the block names the physical page behind the addressed slot, passes the 14-bit offset through unchanged, flags whether the target is ROM, and gates the write enable so that ROM is never written.

Two 8-bit paging registers, primary and secondary, pick the map. A sticky lock flag freezes a fixed legacy map. The three modes take effect in a fixed order of precedence: lock first, then a special all-RAM mode with four fixed layouts, then the normal mode. In normal mode the ROM page index takes one bit from each register.

The translation path is purely combinational. It has no handshake and applies no back-pressure, so every CPU address presented gets a result in the same cycle. Register writes are plain strobes that are taken on the clock edge.

Top module: `mmap_pager`

## Requirements
- R1: After reset both paging registers are zero and the lock is clear. Slot 0 then reads ROM page 0, slot 1 RAM page 5, slot 2 RAM page 2 and slot 3 RAM page 0.
- R2: `mem_addr` is {page, offset}. The page is 3 bits for RAM, and for ROM it is 2 bits with bit 16 held at 0. The offset `mem_addr[13:0]` always equals `cpu_addr[13:0]`. The slot is `cpu_addr[15:14]`.
- R3: In normal mode (lock clear, secondary bit 0 clear), slot 0 is ROM. Its page index is {secondary bit 2, primary bit 4}.
- R4: In normal mode, slot 1 is RAM page 5 and slot 2 is RAM page 2. Slot 3 is the RAM page given by primary bits 2:0.
- R5: With the lock clear and secondary bit 0 set, every slot is RAM and the primary register has no effect. Secondary bits 2:1 select the layout, listed here as the pages for slots 0..3: 00 gives 0,1,2,3; 01 gives 4,5,6,7; 10 gives 4,5,6,3; 11 gives 4,7,6,3.
- R6: Writing the primary register with bit 5 set turns on the lock. While it is on, the map is ROM 0, RAM 5, RAM 2, RAM 0 in slots 0..3, whatever the two registers hold.
- R7: Once set, the lock stays set until reset. While it is set, writes to the primary register are ignored.
- R8: `mem_we` equals `cpu_wr` when the target is RAM and is 0 when the target is ROM.
- R9: A register write (`cfg_we`=1; `cfg_sel` 0 selects primary, 1 selects secondary) is taken on the rising edge. The map changes only for accesses presented after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 1 | Register select: 0 primary, 1 secondary |
| cfg_data | input | 8 | Register write data |
| cpu_addr | input | 16 | CPU address |
| cpu_wr | input | 1 | CPU write request |
| mem_addr | output | 17 | Physical address {page, offset} |
| mem_is_rom | output | 1 | 1 when the target is ROM |
| mem_we | output | 1 | Physical write enable |

## Verification
The bench attacks the precedence order. With the lock on, it loads both registers with values that would pick special or normal maps; a design that tested the special bit before the lock would leak an all-RAM map through. It walks all four special layouts while the primary register holds values that would change slot 3 or the ROM page; a design that let primary through would show those pages. It sweeps all four ROM indices built from the two registers and all eight slot-3 pages, so a swapped ROM index bit would show up as the wrong ROM page. It also checks that a write to ROM drops `mem_we`, that the lock survives both a primary write with bit 5 clear and secondary writes, and that a register write does not change the map before its clock edge.

// File: rtl/mmap_pkg.sv
package mmap_pkg;
  localparam int PAGE_W = 3;

  typedef struct packed {
    logic              is_rom;
    logic [PAGE_W-1:0] page;
  } slot_map_t;

  typedef enum logic [1:0] {MODE_NORMAL, MODE_SPECIAL, MODE_LOCKED} map_mode_e;

  function automatic slot_map_t mk_ram(input logic [PAGE_W-1:0] p);
    slot_map_t m;
    m.is_rom = 1'b0;
    m.page   = p;
    return m;
  endfunction

  function automatic slot_map_t mk_rom(input logic [1:0] p);
    slot_map_t m;
    m.is_rom = 1'b1;
    m.page   = {1'b0, p};
    return m;
  endfunction

  function automatic slot_map_t legacy_map(input int s);
    case (s)
      0:       return mk_rom(2'd0);
      1:       return mk_ram(3'd5);
      2:       return mk_ram(3'd2);
      default: return mk_ram(3'd0);
    endcase
  endfunction

  function automatic slot_map_t special_map(input int s, input logic [1:0] lay);
    logic [PAGE_W-1:0] p;
    case (s)
      0:       p = (lay == 2'd0) ? 3'd0 : 3'd4;
      1:       p = (lay == 2'd0) ? 3'd1 : ((lay == 2'd3) ? 3'd7 : 3'd5);
      2:       p = (lay == 2'd0) ? 3'd2 : 3'd6;
      default: p = (lay == 2'd1) ? 3'd7 : 3'd3;
    endcase
    return mk_ram(p);
  endfunction

  function automatic slot_map_t normal_map(input int s, input logic [1:0] rom_idx,
                                           input logic [PAGE_W-1:0] top_ram);
    case (s)
      0:       return mk_rom(rom_idx);
      1:       return mk_ram(3'd5);
      2:       return mk_ram(3'd2);
      default: return mk_ram(top_ram);
    endcase
  endfunction
endpackage

// File: rtl/mmap_regs.sv
module mmap_regs #(
  parameter int DATA_W   = 8,
  parameter int LOCK_BIT = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic              cfg_sel,
  input  logic [DATA_W-1:0] cfg_data,
  output logic [DATA_W-1:0] pri_q,
  output logic [DATA_W-1:0] sec_q,
  output logic              lock_q
);
  logic pri_wr, sec_wr;

  // A primary write is dropped entirely once the lock is on.
  assign pri_wr = cfg_we && !cfg_sel && !lock_q;
  assign sec_wr = cfg_we &&  cfg_sel;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pri_q  <= '0;
      sec_q  <= '0;
      lock_q <= 1'b0;
    end else begin
      if (pri_wr) begin
        pri_q <= cfg_data;
        if (cfg_data[LOCK_BIT]) lock_q <= 1'b1;
      end
      if (sec_wr) sec_q <= cfg_data;
    end
  end
endmodule

// File: rtl/mmap_slot_table.sv
module mmap_slot_table
  import mmap_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int SLOTS  = 4
) (
  input  logic [DATA_W-1:0]           pri_q,
  input  logic [DATA_W-1:0]           sec_q,
  input  logic                        lock_q,
  output slot_map_t [SLOTS-1:0]       maps
);
  map_mode_e   mode;
  logic [1:0]  rom_idx;
  logic [1:0]  layout;
  logic [PAGE_W-1:0] top_ram;
  logic [DATA_W-1:0] unused_reg_bits;

  assign unused_reg_bits = {pri_q[DATA_W-1:5], pri_q[3], sec_q[DATA_W-1:3]} == '0 ? '0 : '1;

  always_comb begin
    if (lock_q)        mode = MODE_LOCKED;
    else if (sec_q[0]) mode = MODE_SPECIAL;
    else               mode = MODE_NORMAL;
  end

  assign rom_idx = {sec_q[2], pri_q[4]};
  assign layout  = sec_q[2:1];
  assign top_ram = pri_q[PAGE_W-1:0];

  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    always_comb begin
      case (mode)
        MODE_LOCKED:  maps[s] = legacy_map(s);
        MODE_SPECIAL: maps[s] = special_map(s, layout);
        default:      maps[s] = normal_map(s, rom_idx, top_ram);
      endcase
    end
  end
endmodule

// File: rtl/mmap_xlate.sv
module mmap_xlate
  import mmap_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int OFS_W  = 14,
  parameter int SLOTS  = 4
) (
  input  logic [ADDR_W-1:0]      cpu_addr,
  input  logic                   cpu_wr,
  input  slot_map_t [SLOTS-1:0]  maps,
  output logic [PAGE_W+OFS_W-1:0] mem_addr,
  output logic                   mem_is_rom,
  output logic                   mem_we
);
  localparam int SLOT_W = ADDR_W - OFS_W;

  logic [SLOT_W-1:0] slot;
  slot_map_t         hit;

  assign slot       = cpu_addr[ADDR_W-1 -: SLOT_W];
  assign hit        = maps[slot];
  assign mem_addr   = {hit.page, cpu_addr[OFS_W-1:0]};
  assign mem_is_rom = hit.is_rom;
  assign mem_we     = cpu_wr && !hit.is_rom;
endmodule

// File: rtl/mmap_pager.sv
module mmap_pager
  import mmap_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int OFS_W  = 14,
  parameter int DATA_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cfg_we,
  input  logic                    cfg_sel,
  input  logic [DATA_W-1:0]       cfg_data,
  input  logic [ADDR_W-1:0]       cpu_addr,
  input  logic                    cpu_wr,
  output logic [PAGE_W+OFS_W-1:0] mem_addr,
  output logic                    mem_is_rom,
  output logic                    mem_we
);
  localparam int SLOTS = 1 << (ADDR_W - OFS_W);

  logic [DATA_W-1:0]     pri_q, sec_q;
  logic                  lock_q;
  slot_map_t [SLOTS-1:0] maps;

  mmap_regs #(.DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_data(cfg_data), .pri_q(pri_q), .sec_q(sec_q), .lock_q(lock_q)
  );

  mmap_slot_table #(.DATA_W(DATA_W), .SLOTS(SLOTS)) u_table (
    .pri_q(pri_q), .sec_q(sec_q), .lock_q(lock_q), .maps(maps)
  );

  mmap_xlate #(.ADDR_W(ADDR_W), .OFS_W(OFS_W), .SLOTS(SLOTS)) u_xlate (
    .cpu_addr(cpu_addr), .cpu_wr(cpu_wr), .maps(maps),
    .mem_addr(mem_addr), .mem_is_rom(mem_is_rom), .mem_we(mem_we)
  );
endmodule

// File: rtl/mmap_pager_chk.sv
module mmap_pager_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [15:0] cpu_addr,
  input logic        cpu_wr,
  input logic [16:0] mem_addr,
  input logic        mem_is_rom,
  input logic        mem_we,
  input logic        lock_q,
  input logic [7:0]  sec_q
);
  assert_rom_ro_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_is_rom |-> !mem_we);

  assert_ram_wr_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_is_rom && cpu_wr) |-> mem_we);

  assert_lock_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q |=> lock_q);

  assert_lock_map_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_q && cpu_addr[15:14] == 2'd1) |-> (!mem_is_rom && mem_addr[16:14] == 3'd5));

  assert_special_ram_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!lock_q && sec_q[0]) |-> !mem_is_rom);

  assert_offset_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_addr[13:0] == cpu_addr[13:0]);

  assert_rom_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_is_rom |-> !mem_addr[16]);
endmodule

bind mmap_pager mmap_pager_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wr(cpu_wr),
  .mem_addr(mem_addr), .mem_is_rom(mem_is_rom), .mem_we(mem_we),
  .lock_q(lock_q), .sec_q(sec_q)
);

// File: tb/mmap_pager_bench.sv
`timescale 1ns/1ps
module mmap_pager_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0, cfg_sel = 1'b0;
  logic [7:0]  cfg_data = '0;
  logic [15:0] cpu_addr = '0;
  logic        cpu_wr = 1'b0;
  logic [16:0] mem_addr;
  logic        mem_is_rom, mem_we;

  int total = 0, bad = 0;
  bit done = 0;
  logic [7:0] m_pri, m_sec;
  logic       m_lock;

  always #2 clk = ~clk;

  mmap_pager u_mmap_pager (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_data(cfg_data),
    .cpu_addr(cpu_addr), .cpu_wr(cpu_wr),
    .mem_addr(mem_addr), .mem_is_rom(mem_is_rom), .mem_we(mem_we)
  );

  // Expected {is_rom, page} from the requirements text.
  function automatic logic [3:0] model(input logic [1:0] slot);
    logic [1:0] lay;
    if (m_lock) begin
      case (slot) 2'd0: return 4'b1_000; 2'd1: return 4'b0_101;
                  2'd2: return 4'b0_010; default: return 4'b0_000; endcase
    end else if (m_sec[0]) begin
      lay = m_sec[2:1];
      case (lay)
        2'd0: case (slot) 2'd0: return 4'd0; 2'd1: return 4'd1; 2'd2: return 4'd2; default: return 4'd3; endcase
        2'd1: case (slot) 2'd0: return 4'd4; 2'd1: return 4'd5; 2'd2: return 4'd6; default: return 4'd7; endcase
        2'd2: case (slot) 2'd0: return 4'd4; 2'd1: return 4'd5; 2'd2: return 4'd6; default: return 4'd3; endcase
        default: case (slot) 2'd0: return 4'd4; 2'd1: return 4'd7; 2'd2: return 4'd6; default: return 4'd3; endcase
      endcase
    end else begin
      case (slot) 2'd0: return {2'b10, m_sec[2], m_pri[4]}; 2'd1: return 4'b0_101;
                  2'd2: return 4'b0_010; default: return {1'b0, m_pri[2:0]}; endcase
    end
  endfunction

  task automatic check(input string req, input logic [18:0] act, input logic [18:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic probe(input string req, input logic [15:0] a, input logic w);
    logic [3:0] e;
    @(negedge clk);
    cpu_addr = a; cpu_wr = w;
    #1;
    e = model(a[15:14]);
    check(req, {mem_is_rom, mem_we, mem_addr},
          {e[3], w & ~e[3], e[2:0], a[13:0]});
  endtask

  task automatic probe_all(input string req, input logic [13:0] ofs);
    for (int s = 0; s < 4; s++) probe(req, {s[1:0], ofs}, s[0]);
  endtask

  task automatic wr(input logic sel, input logic [7:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_data = d;
    @(negedge clk);
    cfg_we = 1'b0;
    if (sel) m_sec = d;
    else if (!m_lock) begin m_pri = d; if (d[5]) m_lock = 1'b1; end
  endtask

  task automatic do_reset;
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    m_pri = '0; m_sec = '0; m_lock = 1'b0;
  endtask

  task automatic t_reset;   // R1
    do_reset();
    probe_all("R1", 14'h0123);
    probe("R1", 16'h0000, 1'b0);
    probe("R1", 16'hFFFF, 1'b1);
  endtask

  task automatic t_normal;  // R2 R3 R4 R8
    for (int r = 0; r < 4; r++) begin
      wr(1'b1, {5'b0, r[1], 2'b00});
      wr(1'b0, {3'b0, r[0], 4'b0000});
      probe("R3", 16'h3FFF, 1'b1);
      probe("R8", 16'h2000, 1'b1);
    end
    for (int p = 0; p < 8; p++) begin
      wr(1'b0, {5'b10000, p[2:0]});
      probe("R4", 16'hC000 | 16'(p * 16'h0111), 1'b1);
      probe("R4", 16'h4ABC, 1'b0);
      probe("R2", 16'h9555, 1'b1);
    end
  endtask

  task automatic t_special; // R5
    wr(1'b0, 8'h17);
    for (int l = 0; l < 4; l++) begin
      wr(1'b1, {5'b0, l[1:0], 1'b1});
      probe_all("R5", 14'h2AAA);
      probe("R5", 16'h0001, 1'b1);
    end
    wr(1'b0, 8'h02);
    probe_all("R5", 14'h1555);
  endtask

  task automatic t_timing;  // R9
    do_reset();
    @(negedge clk);
    cpu_addr = 16'h0010; cpu_wr = 1'b0;
    cfg_we = 1'b1; cfg_sel = 1'b1; cfg_data = 8'h01;
    #1;
    check("R9", {mem_is_rom, mem_we, mem_addr}, {1'b1, 1'b0, 3'd0, 14'h0010});
    @(posedge clk); #1;
    check("R9", {mem_is_rom, mem_we, mem_addr}, {1'b0, 1'b0, 3'd0, 14'h0010});
    @(negedge clk); cfg_we = 1'b0; m_sec = 8'h01;
  endtask

  task automatic t_lock;    // R6 R7
    do_reset();
    wr(1'b1, 8'h07);
    wr(1'b0, 8'h37);
    probe_all("R6", 14'h0F0F);
    wr(1'b0, 8'h13);
    probe_all("R7", 14'h00FF);
    probe("R7", 16'hC123, 1'b1);
    wr(1'b1, 8'h00);
    wr(1'b1, 8'h04);
    probe_all("R7", 14'h3001);
    probe("R8", 16'h0040, 1'b1);
    do_reset();
    probe_all("R1", 14'h0002);
  endtask

  initial begin
    m_pri = '0; m_sec = '0; m_lock = 1'b0;
    t_reset();
    t_normal();
    t_special();
    t_timing();
    t_lock();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule